// File: doc/BRIEF.md
# Watermark Burst Access Sequencer

This block paces a host that moves 32-bit words to or from a card data buffer in bursts. At a start pulse it captures a watermark level in words, a block size in bytes and a block count. It then cuts every block into bursts. Each burst is watermark words long, except the last burst of a block, which carries whatever is left of that block. So a 4-word watermark with 40-byte blocks gives the burst lengths 4, 4, 2 for each block.

A burst opens only when the buffer can serve all of it. The buffer reports this on `buf_words`, which means the stored data words for a read and the free words for a write. While a burst is open the block raises `burst_req` and shows the burst length. It counts host word strobes until the burst is complete, and it counts down the blocks still to go.

A suspend-type command ends the transfer as an abort. When that happens, the block counter goes back to the count that was programmed at the start, not the number of blocks still left. A block size that is not whole words, or that is zero, is rejected. A block count of zero is rejected as well. A host strobe that arrives while no burst is open is dropped and sets a sticky protocol-error flag.

Top module: `wm_burst_seq`

## Requirements
- R1: After a synchronous reset, `busy`, `burst_req`, `done`, `aborted`, `cfg_err` and `proto_err` are 0 and `blocks_left` is 0.
- R2: A start pulse while idle latches the configuration, sets `busy` on the next cycle and clears `cfg_err` and `proto_err`. A start pulse while `busy` is ignored, and later configuration changes do not affect the transfer in progress.
- R3: Every burst has the clamped watermark length, except the final burst of each block. That burst has the remaining words of the block. Example: watermark 4, 40-byte block, 2 blocks gives 4,4,2,4,4,2.
- R4: With `busy` high and no burst open, `burst_req` rises one cycle after `buf_words` is at least the next burst length. It stays low while `buf_words` is smaller.
- R5: `burst_req` falls in the cycle after the host strobe that completes the burst's word count.
- R6: `blocks_left` decrements at the end of each block and does not change while idle. When the last block ends, `done` pulses for one cycle, `busy` drops and `blocks_left` is 0.
- R7: A start whose block size has a nonzero value in bits [1:0] (not word aligned), or whose size or count is zero, sets `cfg_err` and starts no transfer.
- R8: `cmd_valid` with `cmd_type` equal to 2'b01 (suspend) while `busy` ends the transfer. It pulses `aborted`, closes any burst and reloads `blocks_left` with the count latched at start. Any other `cmd_type` value has no effect.
- R9: A host strobe `acc` while `burst_req` is low is ignored and sets `proto_err`. The flag stays set until reset or an accepted start.
- R10: A watermark of 0, or one larger than the block size in words, is used as the block size in words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse; latches the configuration |
| cfg_wml | input | BYTES_W-2 | Watermark level in words |
| cfg_blk_bytes | input | BYTES_W | Block size in bytes |
| cfg_blk_cnt | input | CNT_W | Number of blocks |
| cmd_valid | input | 1 | Command issued |
| cmd_type | input | 2 | Command type; 2'b01 = suspend |
| buf_words | input | BYTES_W-2 | Words the buffer can serve (data for read, space for write) |
| acc | input | 1 | Host word access strobe |
| busy | output | 1 | Transfer in progress |
| burst_req | output | 1 | Burst open; host may access |
| burst_len | output | BYTES_W-2 | Length of the current burst in words |
| blocks_left | output | CNT_W | Blocks still to transfer |
| done | output | 1 | One-cycle pulse at the end of the transfer |
| aborted | output | 1 | One-cycle pulse on a suspend abort |
| cfg_err | output | 1 | Last start was rejected |
| proto_err | output | 1 | Sticky stray-access flag |

## Verification
A wrong word or burst counter shows up at the ports on the next burst boundary. Either `burst_len` at the rise of `burst_req` differs from the expected pattern, or `burst_req` falls early or late relative to the host strobes. An early fall makes the remaining strobes stray and raises `proto_err`. A wrong block counter shows on `blocks_left` in the cycle after the block's last strobe, and as a missing or early `done`. A wrong reload on suspend shows on `blocks_left` in the cycle right after the command.

// File: rtl/wm_burst_seq.sv
module wm_burst_seq #(
  parameter int BYTES_W = 12,
  parameter int CNT_W   = 8,
  localparam int WDW    = BYTES_W - 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [WDW-1:0]     cfg_wml,
  input  logic [BYTES_W-1:0] cfg_blk_bytes,
  input  logic [CNT_W-1:0]   cfg_blk_cnt,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_type,
  input  logic [WDW-1:0]     buf_words,
  input  logic               acc,
  output logic               busy,
  output logic               burst_req,
  output logic [WDW-1:0]     burst_len,
  output logic [CNT_W-1:0]   blocks_left,
  output logic               done,
  output logic               aborted,
  output logic               cfg_err,
  output logic               proto_err
);
  localparam logic [1:0] CMD_SUSPEND = 2'b01;

  logic             busy_q, open_q, done_q, abort_q, cerr_q, perr_q;
  logic [WDW-1:0]   wml_q, blkw_q, wleft_q, bleft_q, blen_q;
  logic [CNT_W-1:0] orig_q, left_q;

  wire [WDW-1:0] s_words = cfg_blk_bytes[BYTES_W-1:2];
  wire           s_bad   = (cfg_blk_bytes[1:0] != 2'b00) || (s_words == '0) || (cfg_blk_cnt == '0);
  wire [WDW-1:0] s_wml   = ((cfg_wml == '0) || (cfg_wml > s_words)) ? s_words : cfg_wml;
  wire [WDW-1:0] nxt_len = (wml_q < wleft_q) ? wml_q : wleft_q;

  wire suspend = busy_q && cmd_valid && (cmd_type == CMD_SUSPEND);
  wire take    = open_q && acc && !suspend;
  wire stray   = acc && !open_q;
  wire opening = busy_q && !open_q && !suspend && (buf_words >= nxt_len);
  wire blk_end = take && (bleft_q == WDW'(1)) && (wleft_q == WDW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      open_q  <= 1'b0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      cerr_q  <= 1'b0;
      perr_q  <= 1'b0;
      wml_q   <= '0;
      blkw_q  <= '0;
      wleft_q <= '0;
      bleft_q <= '0;
      blen_q  <= '0;
      orig_q  <= '0;
      left_q  <= '0;
    end else begin
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      if (start && !busy_q) begin
        if (s_bad) begin
          cerr_q <= 1'b1;
        end else begin
          cerr_q  <= 1'b0;
          perr_q  <= 1'b0;
          busy_q  <= 1'b1;
          open_q  <= 1'b0;
          wml_q   <= s_wml;
          blkw_q  <= s_words;
          wleft_q <= s_words;
          orig_q  <= cfg_blk_cnt;
          left_q  <= cfg_blk_cnt;
        end
      end else if (suspend) begin
        busy_q  <= 1'b0;
        open_q  <= 1'b0;
        abort_q <= 1'b1;
        left_q  <= orig_q;
      end else if (busy_q) begin
        if (opening) begin
          open_q  <= 1'b1;
          blen_q  <= nxt_len;
          bleft_q <= nxt_len;
        end
        if (take) begin
          bleft_q <= bleft_q - WDW'(1);
          wleft_q <= wleft_q - WDW'(1);
          if (bleft_q == WDW'(1)) open_q <= 1'b0;
        end
        if (blk_end) begin
          wleft_q <= blkw_q;
          left_q  <= left_q - CNT_W'(1);
          if (left_q == CNT_W'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
      if (stray) perr_q <= 1'b1;
    end
  end

  assign busy        = busy_q;
  assign burst_req   = open_q;
  assign burst_len   = blen_q;
  assign blocks_left = left_q;
  assign done        = done_q;
  assign aborted     = abort_q;
  assign cfg_err     = cerr_q;
  assign proto_err   = perr_q;
endmodule

module wm_burst_seq_chk #(
  parameter int BYTES_W = 12,
  parameter int CNT_W   = 8,
  localparam int WDW    = BYTES_W - 2
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [1:0]       blk_lsb,
  input logic             acc,
  input logic             busy,
  input logic             burst_req,
  input logic [WDW-1:0]   burst_len,
  input logic [CNT_W-1:0] blocks_left,
  input logic             done,
  input logic             aborted,
  input logic             cfg_err,
  input logic             proto_err
);
  // R4
  req_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
    burst_req |-> busy);
  // R3
  len_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    burst_req |-> burst_len != '0);
  // R6
  done_final_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !burst_req && blocks_left == '0));
  // R6
  idle_count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(blocks_left));
  // R8
  abort_closes_chk: assert property (@(posedge clk) disable iff (rst)
    aborted |-> (!busy && !burst_req && !done));
  // R7
  misalign_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && blk_lsb != 2'b00) |=> (cfg_err && !busy));
  // R9
  stray_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !burst_req) |=> proto_err);
  // R9
  stray_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (proto_err && !start) |=> proto_err);
endmodule

bind wm_burst_seq wm_burst_seq_chk #(.BYTES_W(BYTES_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .blk_lsb(cfg_blk_bytes[1:0]), .acc(acc),
  .busy(busy), .burst_req(burst_req), .burst_len(burst_len), .blocks_left(blocks_left),
  .done(done), .aborted(aborted), .cfg_err(cfg_err), .proto_err(proto_err));

// File: tb/wm_burst_seq_tb.sv
module wm_burst_seq_tb;
  localparam int BYTES_W = 12;
  localparam int CNT_W   = 8;
  localparam int WDW     = BYTES_W - 2;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, cmd_valid = 1'b0, acc = 1'b0;
  logic [WDW-1:0] cfg_wml = '0, buf_words = '1;
  logic [BYTES_W-1:0] cfg_blk_bytes = '0;
  logic [CNT_W-1:0] cfg_blk_cnt = '0;
  logic [1:0] cmd_type = 2'b00;
  logic busy, burst_req, done, aborted, cfg_err, proto_err;
  logic [WDW-1:0] burst_len;
  logic [CNT_W-1:0] blocks_left;

  int nvec = 0, nbad = 0;
  int expq[$];
  logic req_prev = 1'b0;

  always #4 clk = ~clk;

  wm_burst_seq #(.BYTES_W(BYTES_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .cfg_wml(cfg_wml), .cfg_blk_bytes(cfg_blk_bytes),
    .cfg_blk_cnt(cfg_blk_cnt), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .buf_words(buf_words), .acc(acc), .busy(busy), .burst_req(burst_req),
    .burst_len(burst_len), .blocks_left(blocks_left), .done(done), .aborted(aborted),
    .cfg_err(cfg_err), .proto_err(proto_err));

  task automatic chk(string req, int act, int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: each new burst is compared with the next expected length (R3)
  always @(negedge clk) begin
    if (burst_req && !req_prev) begin
      if (expq.size() == 0) chk("R3 unexpected burst", 1, 0);
      else chk("R3 burst length", int'(burst_len), expq.pop_front());
    end
    req_prev = burst_req;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  function automatic int eff_wml(int wml, int words);
    return (wml == 0 || wml > words) ? words : wml;
  endfunction

  task automatic push_plan(int wml, int bytes, int cnt);
    int w = bytes / 4;
    int e = eff_wml(wml, w);
    for (int b = 0; b < cnt; b++)
      for (int r = w; r > 0; r -= e) expq.push_back(r < e ? r : e);
  endtask

  task automatic kick(int wml, int bytes, int cnt);
    cfg_wml = WDW'(wml); cfg_blk_bytes = BYTES_W'(bytes); cfg_blk_cnt = CNT_W'(cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_burst(int len);
    int guard = 0;
    while (!burst_req && guard < 200) begin @(negedge clk); guard++; end
    if (!burst_req) chk("R4 burst never opened", 0, 1);
    for (int i = 0; i < len; i++) begin acc = 1'b1; @(negedge clk); end
    acc = 1'b0;
    chk("R5 request drops after last access", int'(burst_req), 0);
  endtask

  task automatic run(int wml, int bytes, int cnt);
    int w = bytes / 4;
    int e = eff_wml(wml, w);
    push_plan(wml, bytes, cnt);
    kick(wml, bytes, cnt);
    chk("R2 busy after start", int'(busy), 1);
    chk("R2 cfg_err cleared", int'(cfg_err), 0);
    for (int b = 0; b < cnt; b++) begin
      for (int r = w; r > 0; r -= e) do_burst(r < e ? r : e);
      chk("R6 blocks_left after block", int'(blocks_left), cnt - b - 1);
      if (b == cnt - 1) begin
        chk("R6 done pulse", int'(done), 1);
        chk("R6 busy drops", int'(busy), 0);
      end
    end
    @(negedge clk);
    chk("R6 done is one cycle", int'(done), 0);
    chk("R9 no stray during run", int'(proto_err), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 busy", int'(busy), 0);
    chk("R1 burst_req", int'(burst_req), 0);
    chk("R1 flags", int'({done, aborted, cfg_err, proto_err}), 0);
    chk("R1 blocks_left", int'(blocks_left), 0);

    // R3 burst pattern with remainder: 4,4,2,4,4,2
    run(4, 40, 2);
    run(3, 24, 3);
    run(1, 8, 1);
    // R10 clamping
    run(0, 20, 1);
    run(9, 20, 2);

    // R7 rejections
    kick(4, 42, 1);
    chk("R7 misaligned flagged", int'(cfg_err), 1);
    chk("R7 misaligned no transfer", int'(busy), 0);
    repeat (3) @(negedge clk);
    chk("R7 no burst", int'(burst_req), 0);
    kick(4, 0, 1);
    chk("R7 zero size flagged", int'(cfg_err), 1);
    kick(4, 16, 0);
    chk("R7 zero count flagged", int'(cfg_err), 1);
    chk("R7 zero count no transfer", int'(busy), 0);
    run(2, 8, 1);

    // R4 buffer gating
    buf_words = WDW'(1);
    push_plan(4, 16, 1);
    kick(4, 16, 1);
    repeat (3) @(negedge clk);
    chk("R4 held while buffer short", int'(burst_req), 0);
    buf_words = WDW'(4);
    @(negedge clk);
    chk("R4 opens once buffer ready", int'(burst_req), 1);
    do_burst(4);
    chk("R6 done after gated burst", int'(done), 1);
    buf_words = '1;
    @(negedge clk);

    // R2 start while busy ignored, configuration captured at start
    push_plan(2, 16, 1);
    kick(2, 16, 1);
    cfg_wml = WDW'(1); cfg_blk_bytes = BYTES_W'(12); cfg_blk_cnt = CNT_W'(5);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 blocks_left unchanged by busy start", int'(blocks_left), 1);
    do_burst(2);
    do_burst(2);
    chk("R2 done with latched config", int'(done), 1);
    @(negedge clk);

    // R8 suspend reloads the original count; other types ignored
    push_plan(4, 16, 3);
    kick(4, 16, 3);
    cmd_valid = 1'b1; cmd_type = 2'b10;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R8 other command ignored", int'(busy), 1);
    do_burst(4);
    chk("R8 blocks_left before suspend", int'(blocks_left), 2);
    cmd_valid = 1'b1; cmd_type = 2'b01;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R8 aborted pulse", int'(aborted), 1);
    chk("R8 transfer ended", int'(busy), 0);
    chk("R8 blocks_left reloaded", int'(blocks_left), 3);
    chk("R8 no done on abort", int'(done), 0);
    expq.delete();
    repeat (2) @(negedge clk);
    chk("R8 no burst after abort", int'(burst_req), 0);

    // R9 stray access
    acc = 1'b1;
    @(negedge clk);
    acc = 1'b0;
    chk("R9 stray flagged", int'(proto_err), 1);
    chk("R9 stray ignored", int'(blocks_left), 3);
    repeat (3) @(negedge clk);
    chk("R9 flag sticky", int'(proto_err), 1);
    push_plan(2, 8, 1);
    kick(2, 8, 1);
    chk("R9 cleared by start", int'(proto_err), 0);
    do_burst(2);
    chk("R6 done after restart", int'(done), 1);
    @(negedge clk);
    chk("R3 all expected bursts seen", expq.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule